// File: doc/BRIEF.md
# Debug Port Access Sequencer

This block sits between a client that wants to read or write debug registers and the link engine that moves single transactions over the two-wire debug link. A client request names either a debug-port (DP) register or an access-port (AP) register, together with the AP index, direction and write data. The sequencer expands each request into the link transactions it needs. It writes the DP bank-select register when the target AP or bank has changed. It follows an AP read with a read of the DP read buffer, because AP reads are posted and the buffer carries the real result. When the target reports a fault, it clears the sticky error flags and tries the access once more.

The link engine sees a held request (`lnk_req` with stable fields) and answers with a one-cycle `lnk_done` carrying a 3-bit acknowledge and read data. Acknowledge codes, with bit 0 received first: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. DP registers are addressed by byte offset bits 3:2: 0 = abort, 1 = control/status, 2 = bank select, 3 = read buffer.

State machine, `seq_state_e`:

- IDLE accepts a request and goes to DISPATCH.
- DISPATCH goes to SEL_WR for an AP access that misses the select cache, and otherwise to ACCESS.
- SEL_WR goes to ACCESS on OK.
- ACCESS goes to RDBUF for an AP read, and to RESP for a write or a DP read.
- RDBUF goes to RESP.
- A FAULT in SEL_WR, ACCESS or RDBUF goes to STAT_RD on the first attempt, and to RESP with an error after the retry.
- STAT_RD goes to ABORT_WR.
- ABORT_WR returns to DISPATCH with the retry flag set.
- In every link state, WAIT repeats the transaction up to the limit.
- RESP returns to IDLE.

Top module: `dap_access_seq`

## Requirements
- R1: An AP access to 8-bit address A on AP index S, when preceded by a select write, sends a DP write to offset 0x08 with data (S << 24) | (A[7:4] << 4), then the AP transaction with register index A[3:2].
- R2: The select write is left out when S and A[7:4] equal the pair in the last select write that completed with OK.
- R3: The select cache holds nothing after reset, after a `line_reset` pulse, after a client DP write to offset 0x08, and after a select write that ends in FAULT or error.
- R4: An AP read sends the AP read and then a DP read at offset 0x0C. The data of the second read is the response data.
- R5: A DP access or an AP write uses a single link transaction (after any select write). A DP read returns its data, and a write returns zero data. Read transactions drive `lnk_wdata` to zero.
- R6: On FAULT, the block reads DP offset 0x04 and then writes DP offset 0x00 with bit 0 set. Bit 3 is added when status bit 7 is set, bit 2 when status bit 5 is set, and bit 1 when status bit 4 is set.
- R7: After recovery, the faulted request is restarted once from DISPATCH. A second FAULT ends the request with `rsp_err` = 1 and no further recovery.
- R8: A WAIT acknowledge repeats the identical transaction. After WAIT_LIMIT (default 4) consecutive WAITs the request ends with `rsp_err` = 1.
- R9: An acknowledge other than OK, WAIT or FAULT ends the request at once with `rsp_err` = 1.
- R10: `req_ready` is high only in IDLE, so one request is in flight at a time. Each accepted request yields exactly one single-cycle `rsp_valid`. No link request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_reset | input | 1 | Pulse: link was reset, forget the select cache |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_ap | input | 1 | 1 = AP register, 0 = DP register |
| req_apsel | input | 8 | AP index |
| req_addr | input | 8 | Register byte address (DP uses bits 3:2) |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result |
| rsp_err | output | 1 | Request failed |
| lnk_req | output | 1 | Link transaction requested, held until lnk_done |
| lnk_ap | output | 1 | Link transaction targets AP |
| lnk_reg | output | 2 | Register index (byte offset bits 3:2) |
| lnk_write | output | 1 | Link transaction is a write |
| lnk_wdata | output | 32 | Link write data |
| lnk_done | input | 1 | Link transaction finished |
| lnk_ack | input | 3 | Acknowledge code |
| lnk_rdata | input | 32 | Link read data |

## Verification
The hardest case to reach is a fault on the select write itself. That path has to restart with the cache emptied, so the retry must reissue the select before the access. The bench gets there with a scripted link model that answers each transaction by its position in the request. It first moves the request to a new AP index so that a select write is sure to be first, then answers it with FAULT and gives the status read a value with only bit 4 set. The order of transactions is checked in the log, including the repeated select. The same scripting produces a second fault after recovery and long runs of WAIT.

// File: rtl/dap_seq_pkg.sv
package dap_seq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int BANK_W   = 4;
    localparam int SEL_APSEL_LSB = 24;
    localparam int SEL_BANK_LSB  = 4;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] REG_IDX_ABORT  = 2'd0;
    localparam logic [1:0] REG_IDX_STATUS = 2'd1;
    localparam logic [1:0] REG_IDX_SELECT = 2'd2;
    localparam logic [1:0] REG_IDX_RDBUF  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_SEL_WR,
        ST_ACCESS,
        ST_RDBUF,
        ST_STAT_RD,
        ST_ABORT_WR,
        ST_RESP
    } seq_state_e;

endpackage

// File: rtl/dap_select_cache.sv
module dap_select_cache #(
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inval,
    input  logic               load,
    input  logic [APSEL_W-1:0] ld_apsel,
    input  logic [BANK_W-1:0]  ld_bank,
    input  logic [APSEL_W-1:0] q_apsel,
    input  logic [BANK_W-1:0]  q_bank,
    output logic               hit
);

    logic               valid_q;
    logic [APSEL_W-1:0] apsel_q;
    logic [BANK_W-1:0]  bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            apsel_q <= '0;
            bank_q  <= '0;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            apsel_q <= ld_apsel;
            bank_q  <= ld_bank;
        end
    end

    assign hit = valid_q && (apsel_q == q_apsel) && (bank_q == q_bank);

endmodule

// File: rtl/dap_abort_map.sv
module dap_abort_map
    import dap_seq_pkg::*;
(
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] abort_word
);

    localparam int ST_WDATA_ERR = 7;
    localparam int ST_STICKY_ER = 5;
    localparam int ST_STICKY_CM = 4;

    logic unused_status_bits;
    assign unused_status_bits = ^{status[DATA_W-1:8], status[6], status[3:0]};

    always_comb begin
        abort_word    = '0;
        abort_word[0] = 1'b1;
        abort_word[3] = status[ST_WDATA_ERR];
        abort_word[2] = status[ST_STICKY_ER];
        abort_word[1] = status[ST_STICKY_CM];
    end

endmodule

// File: rtl/dap_seq_fsm.sv
module dap_seq_fsm
    import dap_seq_pkg::*;
#(
    parameter int APSEL_W    = 8,
    parameter int WAIT_LIMIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_ap,
    input  logic [APSEL_W-1:0] req_apsel,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err,
    output logic               lnk_req,
    output logic               lnk_ap,
    output logic [1:0]         lnk_reg,
    output logic               lnk_write,
    output logic [DATA_W-1:0]  lnk_wdata,
    input  logic               lnk_done,
    input  logic [2:0]         lnk_ack,
    input  logic [DATA_W-1:0]  lnk_rdata,
    input  logic               cache_hit,
    output logic               cache_load,
    output logic               cache_inval,
    output logic [APSEL_W-1:0] cur_apsel,
    output logic [BANK_W-1:0]  cur_bank,
    output logic [DATA_W-1:0]  status_out,
    input  logic [DATA_W-1:0]  abort_word,
    output seq_state_e         phase
);

    localparam int WCNT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(WAIT_LIMIT - 1);

    seq_state_e state_q, state_d;

    logic               cap_ap_q, cap_ap_d;
    logic [APSEL_W-1:0] cap_apsel_q, cap_apsel_d;
    logic [ADDR_W-1:2]  cap_addr_q, cap_addr_d;
    logic               cap_write_q, cap_write_d;
    logic [DATA_W-1:0]  cap_wdata_q, cap_wdata_d;
    logic               retried_q, retried_d;
    logic [WCNT_W-1:0]  wait_q, wait_d;
    logic [DATA_W-1:0]  status_q, status_d;
    logic [DATA_W-1:0]  result_q, result_d;
    logic               err_q, err_d;

    logic unused_addr_lsbs;
    assign unused_addr_lsbs = ^req_addr[1:0];

    logic ack_ok, ack_wait, ack_fault;
    assign ack_ok    = (lnk_ack == ACK_OK);
    assign ack_wait  = (lnk_ack == ACK_WAIT);
    assign ack_fault = (lnk_ack == ACK_FAULT);

    logic [1:0] cap_reg;
    assign cap_reg   = cap_addr_q[3:2];
    assign cur_apsel = cap_apsel_q;
    assign cur_bank  = cap_addr_q[ADDR_W-1:4];
    assign status_out = status_q;
    assign phase     = state_q;

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cap_ap_q    <= 1'b0;
            cap_apsel_q <= '0;
            cap_addr_q  <= '0;
            cap_write_q <= 1'b0;
            cap_wdata_q <= '0;
            retried_q   <= 1'b0;
            wait_q      <= '0;
            status_q    <= '0;
            result_q    <= '0;
            err_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            cap_ap_q    <= cap_ap_d;
            cap_apsel_q <= cap_apsel_d;
            cap_addr_q  <= cap_addr_d;
            cap_write_q <= cap_write_d;
            cap_wdata_q <= cap_wdata_d;
            retried_q   <= retried_d;
            wait_q      <= wait_d;
            status_q    <= status_d;
            result_q    <= result_d;
            err_q       <= err_d;
        end
    end

    // Next state and datapath
    always_comb begin
        logic       is_link;
        logic       can_recover;
        seq_state_e ok_next;

        state_d     = state_q;
        cap_ap_d    = cap_ap_q;
        cap_apsel_d = cap_apsel_q;
        cap_addr_d  = cap_addr_q;
        cap_write_d = cap_write_q;
        cap_wdata_d = cap_wdata_q;
        retried_d   = retried_q;
        wait_d      = wait_q;
        status_d    = status_q;
        result_d    = result_q;
        err_d       = err_q;
        cache_load  = 1'b0;
        cache_inval = 1'b0;
        is_link     = 1'b0;
        can_recover = 1'b0;
        ok_next     = state_q;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cap_ap_d    = req_ap;
                    cap_apsel_d = req_apsel;
                    cap_addr_d  = req_addr[ADDR_W-1:2];
                    cap_write_d = req_write;
                    cap_wdata_d = req_wdata;
                    retried_d   = 1'b0;
                    wait_d      = '0;
                    result_d    = '0;
                    err_d       = 1'b0;
                    state_d     = ST_DISPATCH;
                end
            end
            ST_DISPATCH: begin
                state_d = (cap_ap_q && !cache_hit) ? ST_SEL_WR : ST_ACCESS;
            end
            ST_SEL_WR: begin
                is_link     = 1'b1;
                can_recover = 1'b1;
                ok_next     = ST_ACCESS;
                if (lnk_done && !ack_wait) begin
                    cache_load  = ack_ok;
                    cache_inval = !ack_ok;
                end
            end
            ST_ACCESS: begin
                is_link     = 1'b1;
                can_recover = 1'b1;
                if (cap_write_q)   ok_next = ST_RESP;
                else if (cap_ap_q) ok_next = ST_RDBUF;
                else               ok_next = ST_RESP;
                if (lnk_done && !cap_ap_q && cap_write_q && cap_reg == REG_IDX_SELECT)
                    cache_inval = 1'b1;
                if (lnk_done && ack_ok && !cap_write_q && !cap_ap_q)
                    result_d = lnk_rdata;
            end
            ST_RDBUF: begin
                is_link     = 1'b1;
                can_recover = 1'b1;
                ok_next     = ST_RESP;
                if (lnk_done && ack_ok)
                    result_d = lnk_rdata;
            end
            ST_STAT_RD: begin
                is_link = 1'b1;
                ok_next = ST_ABORT_WR;
                if (lnk_done && ack_ok)
                    status_d = lnk_rdata;
            end
            ST_ABORT_WR: begin
                is_link = 1'b1;
                ok_next = ST_DISPATCH;
                if (lnk_done && ack_ok)
                    retried_d = 1'b1;
            end
            ST_RESP: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase

        if (is_link && lnk_done) begin
            if (ack_wait) begin
                if (wait_q == WAIT_LAST) begin
                    wait_d  = '0;
                    err_d   = 1'b1;
                    state_d = ST_RESP;
                end else begin
                    wait_d = wait_q + 1'b1;
                end
            end else begin
                wait_d = '0;
                if (ack_ok) begin
                    state_d = ok_next;
                end else if (ack_fault && can_recover && !retried_q) begin
                    state_d = ST_STAT_RD;
                end else begin
                    err_d    = 1'b1;
                    result_d = '0;
                    state_d  = ST_RESP;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        lnk_req   = 1'b0;
        lnk_ap    = 1'b0;
        lnk_reg   = '0;
        lnk_write = 1'b0;
        lnk_wdata = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_DISPATCH: ;
            ST_SEL_WR: begin
                lnk_req   = 1'b1;
                lnk_reg   = REG_IDX_SELECT;
                lnk_write = 1'b1;
                lnk_wdata = (DATA_W'(cap_apsel_q) << SEL_APSEL_LSB)
                          | (DATA_W'(cap_addr_q[ADDR_W-1:4]) << SEL_BANK_LSB);
            end
            ST_ACCESS: begin
                lnk_req   = 1'b1;
                lnk_ap    = cap_ap_q;
                lnk_reg   = cap_reg;
                lnk_write = cap_write_q;
                lnk_wdata = cap_write_q ? cap_wdata_q : '0;
            end
            ST_RDBUF: begin
                lnk_req = 1'b1;
                lnk_reg = REG_IDX_RDBUF;
            end
            ST_STAT_RD: begin
                lnk_req = 1'b1;
                lnk_reg = REG_IDX_STATUS;
            end
            ST_ABORT_WR: begin
                lnk_req   = 1'b1;
                lnk_reg   = REG_IDX_ABORT;
                lnk_write = 1'b1;
                lnk_wdata = abort_word;
            end
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_rdata = result_q;
    assign rsp_err   = err_q;

endmodule

// File: rtl/dap_access_seq.sv
module dap_access_seq
    import dap_seq_pkg::*;
#(
    parameter int APSEL_W    = 8,
    parameter int WAIT_LIMIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_reset,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_ap,
    input  logic [APSEL_W-1:0] req_apsel,
    input  logic [7:0]         req_addr,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_err,
    output logic               lnk_req,
    output logic               lnk_ap,
    output logic [1:0]         lnk_reg,
    output logic               lnk_write,
    output logic [31:0]        lnk_wdata,
    input  logic               lnk_done,
    input  logic [2:0]         lnk_ack,
    input  logic [31:0]        lnk_rdata
);

    logic               cache_hit;
    logic               cache_load;
    logic               fsm_inval;
    logic [APSEL_W-1:0] cur_apsel;
    logic [BANK_W-1:0]  cur_bank;
    logic [DATA_W-1:0]  status_w;
    logic [DATA_W-1:0]  abort_w;
    seq_state_e         seq_phase;

    dap_select_cache #(.APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .inval    (line_reset | fsm_inval),
        .load     (cache_load),
        .ld_apsel (cur_apsel),
        .ld_bank  (cur_bank),
        .q_apsel  (cur_apsel),
        .q_bank   (cur_bank),
        .hit      (cache_hit)
    );

    dap_abort_map u_abort (
        .status     (status_w),
        .abort_word (abort_w)
    );

    dap_seq_fsm #(.APSEL_W(APSEL_W), .WAIT_LIMIT(WAIT_LIMIT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_ap      (req_ap),
        .req_apsel   (req_apsel),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .lnk_req     (lnk_req),
        .lnk_ap      (lnk_ap),
        .lnk_reg     (lnk_reg),
        .lnk_write   (lnk_write),
        .lnk_wdata   (lnk_wdata),
        .lnk_done    (lnk_done),
        .lnk_ack     (lnk_ack),
        .lnk_rdata   (lnk_rdata),
        .cache_hit   (cache_hit),
        .cache_load  (cache_load),
        .cache_inval (fsm_inval),
        .cur_apsel   (cur_apsel),
        .cur_bank    (cur_bank),
        .status_out  (status_w),
        .abort_word  (abort_w),
        .phase       (seq_phase)
    );

endmodule

// File: rtl/dap_access_seq_checker.sv
module dap_access_seq_checker
    import dap_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        lnk_req,
    input logic        lnk_done,
    input logic        lnk_ap,
    input logic [1:0]  lnk_reg,
    input logic        lnk_write,
    input logic [31:0] lnk_wdata,
    input seq_state_e  seq_phase
);

    // R10: nothing new is accepted while a request is in flight
    p_single_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: completion is a single-cycle pulse
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: no link traffic while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lnk_req);

    // R8: a pending link transaction keeps its fields until answered
    p_link_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && !lnk_done) |=> (lnk_req && $stable(lnk_wdata) && $stable(lnk_reg)
                                    && $stable(lnk_write) && $stable(lnk_ap)));

    // R4: the follow-up of a posted read targets the read buffer
    p_rdbuf_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && seq_phase == ST_RDBUF) |-> (!lnk_ap && !lnk_write && lnk_reg == 2'd3));

    // R6: recovery reads status and writes abort with bit 0 set
    p_status_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && seq_phase == ST_STAT_RD) |-> (!lnk_ap && !lnk_write && lnk_reg == 2'd1));

    p_abort_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && seq_phase == ST_ABORT_WR) |-> (!lnk_ap && lnk_write && lnk_reg == 2'd0
                                                   && lnk_wdata[0]));

    // R1: select writes go to DP offset 0x08
    p_select_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && seq_phase == ST_SEL_WR) |-> (!lnk_ap && lnk_write && lnk_reg == 2'd2));

endmodule

bind dap_access_seq dap_access_seq_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .lnk_req   (lnk_req),
    .lnk_done  (lnk_done),
    .lnk_ap    (lnk_ap),
    .lnk_reg   (lnk_reg),
    .lnk_write (lnk_write),
    .lnk_wdata (lnk_wdata),
    .seq_phase (seq_phase)
);

// File: tb/dap_access_seq_bench.sv
`timescale 1ns/1ps
module dap_access_seq_bench;

    localparam logic [2:0] OK    = 3'b001;
    localparam logic [2:0] WAITA = 3'b010;
    localparam logic [2:0] FLT   = 3'b100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_ap = 1'b0;
    logic [7:0]  req_apsel = '0;
    logic [7:0]  req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        lnk_req;
    logic        lnk_ap;
    logic [1:0]  lnk_reg;
    logic        lnk_write;
    logic [31:0] lnk_wdata;
    logic        lnk_done = 1'b0;
    logic [2:0]  lnk_ack = '0;
    logic [31:0] lnk_rdata = '0;

    always #2.5 clk = ~clk;

    dap_access_seq u_dap_access_seq (
        .clk(clk), .rst_n(rst_n), .line_reset(line_reset),
        .req_valid(req_valid), .req_ready(req_ready), .req_ap(req_ap),
        .req_apsel(req_apsel), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .lnk_req(lnk_req), .lnk_ap(lnk_ap), .lnk_reg(lnk_reg),
        .lnk_write(lnk_write), .lnk_wdata(lnk_wdata), .lnk_done(lnk_done),
        .lnk_ack(lnk_ack), .lnk_rdata(lnk_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [2:0]  sc_ack [32];
    logic [31:0] sc_dat [32];
    logic [35:0] log_q  [32];
    int          n_log = 0;

    logic [31:0] got_rdata;
    logic        got_err;

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_script();
        for (int i = 0; i < 32; i++) begin
            sc_ack[i] = OK;
            sc_dat[i] = 32'hA500_0000 + 32'(i * 17);
        end
        n_log = 0;
    endtask

    function automatic logic [35:0] txn(input logic ap, input logic [1:0] r,
                                        input logic wr, input logic [31:0] wd);
        return {ap, r, wr, wd};
    endfunction

    function automatic logic [31:0] abort_of(input logic [31:0] st);
        return 32'd1 | (st[7] ? 32'd8 : 32'd0) | (st[5] ? 32'd4 : 32'd0)
                     | (st[4] ? 32'd2 : 32'd0);
    endfunction

    // Link engine model: answers each transaction by its index in the script
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && lnk_req && !lnk_done) begin
                if (n_log < 32) log_q[n_log] = {lnk_ap, lnk_reg, lnk_write, lnk_wdata};
                repeat (2) @(negedge clk);
                lnk_ack   = sc_ack[n_log % 32];
                lnk_rdata = sc_dat[n_log % 32];
                lnk_done  = 1'b1;
                n_log++;
                @(negedge clk);
                lnk_done  = 1'b0;
            end
        end
    end

    task automatic issue(input string tag, input logic ap, input logic [7:0] sel,
                         input logic [7:0] addr, input logic wr, input logic [31:0] wd);
        bit seen;
        @(negedge clk);
        req_ap = ap; req_apsel = sel; req_addr = addr; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 busy ready"}, 36'(req_ready), 36'd0);
        seen = 1'b0;
        for (int c = 0; c < 3000 && !seen; c++) begin
            @(negedge clk);
            if (rsp_valid) begin
                seen = 1'b1;
                got_rdata = rsp_rdata;
                got_err = rsp_err;
            end
        end
        chk({tag, " R10 response seen"}, 36'(seen), 36'd1);
        @(negedge clk);
        chk({tag, " R10 response pulse"}, 36'(rsp_valid), 36'd0);
    endtask

    task automatic t_reset();
        chk("R10 reset ready", 36'(req_ready), 36'd1);
        chk("R10 reset rsp_valid", 36'(rsp_valid), 36'd0);
        chk("R10 reset lnk_req", 36'(lnk_req), 36'd0);
    endtask

    task automatic t_ap_read_miss();
        clear_script();
        issue("R4 first", 1, 8'h02, 8'hF4, 0, 0);
        chk("R1 count", 36'(n_log), 36'd3);
        chk("R1 select", log_q[0], txn(0, 2'd2, 1, 32'h0200_00F0));
        chk("R1 ap read", log_q[1], txn(1, 2'd1, 0, 0));
        chk("R4 rdbuf", log_q[2], txn(0, 2'd3, 0, 0));
        chk("R4 data", 36'(got_rdata), 36'(sc_dat[2]));
        chk("R4 err", 36'(got_err), 36'd0);
    endtask

    task automatic t_ap_read_hit();
        clear_script();
        issue("R2 hit", 1, 8'h02, 8'hFC, 0, 0);
        chk("R2 count", 36'(n_log), 36'd2);
        chk("R2 ap read", log_q[0], txn(1, 2'd3, 0, 0));
        chk("R4 data hit", 36'(got_rdata), 36'(sc_dat[1]));
    endtask

    task automatic t_ap_write_bank();
        clear_script();
        issue("R5 ap write", 1, 8'h02, 8'h04, 1, 32'h1234_5678);
        chk("R5 count", 36'(n_log), 36'd2);
        chk("R1 select bank0", log_q[0], txn(0, 2'd2, 1, 32'h0200_0000));
        chk("R5 write txn", log_q[1], txn(1, 2'd1, 1, 32'h1234_5678));
        chk("R5 write rdata", 36'(got_rdata), 36'd0);
    endtask

    task automatic t_dp_read();
        clear_script();
        issue("R5 dp read", 0, 8'h00, 8'h04, 0, 0);
        chk("R5 dp count", 36'(n_log), 36'd1);
        chk("R5 dp txn", log_q[0], txn(0, 2'd1, 0, 0));
        chk("R5 dp data", 36'(got_rdata), 36'(sc_dat[0]));
    endtask

    task automatic t_line_reset();
        @(negedge clk); line_reset = 1'b1;
        @(negedge clk); line_reset = 1'b0;
        clear_script();
        issue("R3 line reset", 1, 8'h02, 8'h08, 1, 32'h55);
        chk("R3 lr count", 36'(n_log), 36'd2);
        chk("R3 lr select", log_q[0], txn(0, 2'd2, 1, 32'h0200_0000));
        chk("R3 lr write", log_q[1], txn(1, 2'd2, 1, 32'h55));
    endtask

    task automatic t_client_select();
        clear_script();
        issue("R3 client sel", 0, 8'h00, 8'h08, 1, 32'h0);
        chk("R3 cs count", 36'(n_log), 36'd1);
        clear_script();
        issue("R3 after sel", 1, 8'h02, 8'h00, 0, 0);
        chk("R3 as count", 36'(n_log), 36'd3);
        chk("R3 as select", log_q[0], txn(0, 2'd2, 1, 32'h0200_0000));
    endtask

    task automatic t_fault_recover();
        clear_script();
        sc_ack[0] = FLT;
        sc_dat[1] = 32'h0000_00B0;
        issue("R7 recover", 1, 8'h02, 8'h0C, 1, 32'hCAFE_0001);
        chk("R7 count", 36'(n_log), 36'd4);
        chk("R6 status read", log_q[1], txn(0, 2'd1, 0, 0));
        chk("R6 abort B0", log_q[2], txn(0, 2'd0, 1, abort_of(32'hB0)));
        chk("R7 retry", log_q[3], txn(1, 2'd3, 1, 32'hCAFE_0001));
        chk("R7 err clear", 36'(got_err), 36'd0);
    endtask

    task automatic t_double_fault();
        clear_script();
        sc_ack[0] = FLT;
        sc_dat[1] = 32'h0000_0020;
        sc_ack[3] = FLT;
        issue("R7 double", 1, 8'h02, 8'h00, 0, 0);
        chk("R7 dbl count", 36'(n_log), 36'd4);
        chk("R6 abort 20", log_q[2], txn(0, 2'd0, 1, abort_of(32'h20)));
        chk("R7 dbl retry", log_q[3], txn(1, 2'd0, 0, 0));
        chk("R7 dbl err", 36'(got_err), 36'd1);
    endtask

    task automatic t_select_fault();
        clear_script();
        sc_ack[0] = FLT;
        sc_dat[1] = 32'h0000_0010;
        issue("R3 sel fault", 1, 8'h05, 8'h14, 1, 32'h77);
        chk("R3 sf count", 36'(n_log), 36'd5);
        chk("R1 sf select", log_q[0], txn(0, 2'd2, 1, 32'h0500_0010));
        chk("R6 abort 10", log_q[2], txn(0, 2'd0, 1, abort_of(32'h10)));
        chk("R3 reselect", log_q[3], txn(0, 2'd2, 1, 32'h0500_0010));
        chk("R3 sf write", log_q[4], txn(1, 2'd1, 1, 32'h77));
        chk("R3 sf err", 36'(got_err), 36'd0);
    endtask

    task automatic t_wait_retry();
        clear_script();
        sc_ack[0] = WAITA;
        sc_ack[1] = WAITA;
        issue("R8 wait", 0, 8'h00, 8'h0C, 0, 0);
        chk("R8 count", 36'(n_log), 36'd3);
        chk("R8 same txn", log_q[1], log_q[0]);
        chk("R8 same txn2", log_q[2], txn(0, 2'd3, 0, 0));
        chk("R8 data", 36'(got_rdata), 36'(sc_dat[2]));
        chk("R8 err", 36'(got_err), 36'd0);
    endtask

    task automatic t_wait_limit();
        clear_script();
        for (int i = 0; i < 8; i++) sc_ack[i] = WAITA;
        issue("R8 limit", 0, 8'h00, 8'h04, 0, 0);
        repeat (10) @(negedge clk);
        chk("R8 limit count", 36'(n_log), 36'd4);
        chk("R8 limit err", 36'(got_err), 36'd1);
    endtask

    task automatic t_bad_ack();
        clear_script();
        sc_ack[0] = 3'b111;
        issue("R9 bad ack", 0, 8'h00, 8'h04, 0, 0);
        chk("R9 count", 36'(n_log), 36'd1);
        chk("R9 err", 36'(got_err), 36'd1);
    endtask

    initial begin
        clear_script();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ap_read_miss();
        t_ap_read_hit();
        t_ap_write_bank();
        t_dp_read();
        t_line_reset();
        t_client_select();
        t_fault_recover();
        t_double_fault();
        t_select_fault();
        t_wait_retry();
        t_wait_limit();
        t_bad_ack();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule